// File: doc/BRIEF.md
# Streaming convolution and pooling node

This block is one physical node of a small image-classification pipeline. It takes a single grayscale image slice as a raster-scan pixel stream, one pixel per clock when the producer has one. It keeps a sliding 3x3 window in a shift store that spans two image rows plus three pixels, and multiplies the window against nine signed weights loaded through a simple write port. It clamps negative sums to zero and averages each non-overlapping 2x2 block of the activated map. The pooled feature map leaves as a valid-qualified stream, also in raster order.

A frame is opened by a one-cycle frame-start pulse. This pulse resets the position counters and empties the window store, so nothing carries over from a previous slice. Window taps that fall outside the image read as zero, which keeps the convolution map at the input size before pooling. Once the last pixel of a slice has been taken, the node produces the padding cycles it needs for the bottom row and right edge by itself, one per clock, and then goes idle until the next frame start.

Top module: `conv_pool_node`

## Requirements
- R1: After reset, and whenever no frame is open, `out_valid` stays low and asserted `pix_valid` has no effect. A frame is opened only by `frame_start`.
- R2: The weights are nine signed 8-bit values written with `wgt_we`, `wgt_sel` and `wgt_data`. Selector k = 3*(dy+1) + (dx+1) applies to the pixel at row offset dy and column offset dx from the centre, with dy,dx in {-1,0,1}: 0 is above-left, 4 is the centre, 8 is below-right. Selector values 9 to 15 are ignored. All weights reset to zero.
- R3: The convolution value at image position (r,c) is the signed sum over the nine taps of weight times pixel. Pixels are unsigned 8-bit. Taps outside the 16x16 image read as zero, whether they fall off a row edge or off a column edge.
- R4: Negative convolution values are replaced by zero before pooling. Every pooled output lies between 0 and 9*255*127.
- R5: Each pooled output is the floor of one quarter of the sum of the four activated values of a non-overlapping 2x2 block. A 16x16 slice gives 64 outputs, issued in raster order of the blocks.
- R6: Let s count the stream positions of a frame from 0. Positions 0 to 255 are accepted pixels, and positions 256 to 272 are the self-generated padding cycles. The output for block (i,j) is high on `out_valid` for exactly one cycle, two clock edges after the edge that takes position s = (2i+1)*16 + (2j+1) + 17. No output appears at any other time.
- R7: A pixel is accepted on every clock edge where `pix_valid` is high in an open frame, at most one per edge. Low `pix_valid` cycles stall the stream without changing any result.
- R8: After pixel 255, the 17 padding positions follow on consecutive clocks with no input needed. `pix_valid` during and after them is ignored until the next `frame_start`.
- R9: `frame_start` empties the window store and restarts counting. A partly sent frame is abandoned: none of its results appear after the edge that samples `frame_start`, and the new frame's results do not depend on it.
- R10: A pixel presented in the same cycle as `frame_start` is not accepted. The first pixel of a frame is the first one after the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that opens a new slice |
| pix_valid | input | 1 | Pixel qualifier |
| pix_data | input | 8 | Unsigned grayscale pixel |
| wgt_we | input | 1 | Weight write strobe |
| wgt_sel | input | 4 | Weight selector, 0 to 8 |
| wgt_data | input | 8 | Signed weight value |
| out_valid | output | 1 | Pooled result qualifier |
| out_data | output | 20 | Pooled, activated result |

## Verification
Every pooled result is due exactly two clock edges after the edge that consumes stream position (2i+1)*16+(2j+1)+17, and that position may be a self-generated padding cycle. The bench model counts positions the same way from the ports alone. It stamps each expected result with that edge number plus two, and on every falling edge compares `out_valid` and `out_data` against the head of its queue, so an early, late, missing or extra result is caught in its own cycle. A `frame_start` empties the model queue at the edge that samples it, which is the cycle after which no abandoned result may appear.

// File: rtl/cpn_pkg.sv
package cpn_pkg;
    localparam int KSZ  = 3;
    localparam int HALF = KSZ / 2;
    localparam int NTAP = KSZ * KSZ;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUN   = 2'd1,
        PH_FLUSH = 2'd2
    } phase_e;
endpackage

// File: rtl/cpn_window.sv
module cpn_window
    import cpn_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 16,
    parameter int PIX_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_start_i,
    input  logic                          pix_valid_i,
    input  logic [PIX_W-1:0]              pix_i,
    output logic [NTAP-1:0][PIX_W-1:0]    taps_o,
    output logic                          cen_valid_o,
    output logic                          cen_rodd_o,
    output logic [$clog2(IMG_W)-1:0]      cen_c_o
);
    localparam int ROW_W  = $clog2(IMG_H);
    localparam int COL_W  = $clog2(IMG_W);
    localparam int SR_LEN = (KSZ - 1) * IMG_W + KSZ;
    localparam int NPIX   = IMG_W * IMG_H;
    localparam int NTICK  = NPIX + HALF * IMG_W + HALF;
    localparam int CNT_W  = $clog2(NTICK + 1);
    localparam logic [CNT_W-1:0] FIRST_CEN = CNT_W'(HALF * IMG_W + HALF);
    localparam logic [CNT_W-1:0] LAST_PIX  = CNT_W'(NPIX - 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(NTICK - 1);
    localparam logic [COL_W-1:0] COL_LAST  = COL_W'(IMG_W - 1);

    typedef struct packed {
        phase_e                        phase;
        logic [CNT_W-1:0]              cnt;
        logic [SR_LEN-1:0][PIX_W-1:0]  sr;
        logic [ROW_W-1:0]              nr;
        logic [COL_W-1:0]              nc;
        logic                          cv;
        logic                          crodd;
        logic [COL_W-1:0]              cc;
    } win_t;

    win_t             st_d, st_q;
    logic             tick;
    logic [PIX_W-1:0] shin;

    always_comb begin
        st_d    = st_q;
        st_d.cv = 1'b0;
        tick    = 1'b0;
        shin    = '0;
        if (frame_start_i) begin
            st_d.phase = PH_RUN;
            st_d.cnt   = '0;
            st_d.sr    = '0;
            st_d.nr    = '0;
            st_d.nc    = '0;
        end else begin
            case (st_q.phase)
                PH_RUN: begin
                    if (pix_valid_i) begin
                        tick = 1'b1;
                        shin = pix_i;
                    end
                end
                PH_FLUSH: tick = 1'b1;
                default: ;
            endcase
            if (tick) begin
                st_d.sr  = {st_q.sr[SR_LEN-2:0], shin};
                st_d.cnt = st_q.cnt + CNT_W'(1);
                if (st_q.cnt >= FIRST_CEN) begin
                    st_d.cv    = 1'b1;
                    st_d.crodd = st_q.nr[0];
                    st_d.cc    = st_q.nc;
                    if (st_q.nc == COL_LAST) begin
                        st_d.nc = '0;
                        st_d.nr = st_q.nr + ROW_W'(1);
                    end else begin
                        st_d.nc = st_q.nc + COL_W'(1);
                    end
                end
                if (st_q.phase == PH_RUN && st_q.cnt == LAST_PIX) begin
                    st_d.phase = PH_FLUSH;
                end
                if (st_q.phase == PH_FLUSH && st_q.cnt == LAST_TICK) begin
                    st_d.phase = PH_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Tap (dr,dc) of the window centred at position m reads pixel m+(dr-1)*W+(dc-1).
    // Row overrun reads the cleared store or flush zeros; column overrun is masked.
    for (genvar dr = 0; dr < KSZ; dr++) begin : g_row
        for (genvar dc = 0; dc < KSZ; dc++) begin : g_col
            localparam int SRI = SR_LEN - 1 - dr * IMG_W - dc;
            logic edge_cut;
            if (dc < HALF) begin : g_left
                assign edge_cut = (st_q.cc < COL_W'(HALF - dc));
            end else if (dc > HALF) begin : g_right
                assign edge_cut = (st_q.cc > COL_W'(IMG_W - 1 - (dc - HALF)));
            end else begin : g_mid
                assign edge_cut = 1'b0;
            end
            assign taps_o[dr*KSZ+dc] = edge_cut ? '0 : st_q.sr[SRI];
        end
    end

    assign cen_valid_o = st_q.cv;
    assign cen_rodd_o  = st_q.crodd;
    assign cen_c_o     = st_q.cc;

    p_idle_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && !frame_start_i) |=> ($stable(st_q.sr) && $stable(st_q.cnt)));

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> (st_q.cnt == $past(st_q.cnt) || st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    p_flush_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_FLUSH && !frame_start_i) |=> (st_q.sr[0] == '0));
endmodule

// File: rtl/cpn_mac.sv
module cpn_mac
    import cpn_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int PIX_W = 8,
    parameter int WGT_W = 8,
    parameter int ACC_W = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_start_i,
    input  logic                          wgt_we_i,
    input  logic [$clog2(NTAP)-1:0]       wgt_sel_i,
    input  logic [WGT_W-1:0]              wgt_i,
    input  logic [NTAP-1:0][PIX_W-1:0]    taps_i,
    input  logic                          cen_valid_i,
    input  logic                          cen_rodd_i,
    input  logic [$clog2(IMG_W)-1:0]      cen_c_i,
    output logic                          conv_valid_o,
    output logic                          conv_rodd_o,
    output logic [$clog2(IMG_W)-1:0]      conv_c_o,
    output logic [ACC_W-1:0]              conv_o
);
    localparam int COL_W = $clog2(IMG_W);
    localparam int SEL_W = $clog2(NTAP);

    typedef struct packed {
        logic [NTAP-1:0][WGT_W-1:0] wts;
        logic                       v;
        logic                       rodd;
        logic [COL_W-1:0]           c;
        logic [ACC_W-1:0]           act;
    } mac_t;

    mac_t                    st_d, st_q;
    logic signed [ACC_W-1:0] acc, pe, we;

    always_comb begin
        st_d = st_q;
        if (wgt_we_i && wgt_sel_i < SEL_W'(NTAP)) begin
            st_d.wts[wgt_sel_i] = wgt_i;
        end
        acc = '0;
        pe  = '0;
        we  = '0;
        for (int t = 0; t < NTAP; t++) begin
            pe  = ACC_W'($signed({1'b0, taps_i[t]}));
            we  = ACC_W'($signed(st_q.wts[t]));
            acc = acc + pe * we;
        end
        st_d.v    = cen_valid_i && !frame_start_i;
        st_d.rodd = cen_rodd_i;
        st_d.c    = cen_c_i;
        st_d.act  = acc[ACC_W-1] ? '0 : acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign conv_valid_o = st_q.v;
    assign conv_rodd_o  = st_q.rodd;
    assign conv_c_o     = st_q.c;
    assign conv_o       = st_q.act;

    p_conv_after_center_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid_o |-> $past(cen_valid_i));

    p_weight_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wgt_we_i |=> $stable(st_q.wts));
endmodule

// File: rtl/cpn_pool.sv
module cpn_pool #(
    parameter int IMG_W = 16,
    parameter int PIX_W = 8,
    parameter int WGT_W = 8,
    parameter int ACC_W = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start_i,
    input  logic                      conv_valid_i,
    input  logic                      conv_rodd_i,
    input  logic [$clog2(IMG_W)-1:0]  conv_c_i,
    input  logic [ACC_W-1:0]          conv_i,
    output logic                      out_valid_o,
    output logic [ACC_W-1:0]          out_o
);
    localparam int COL_W  = $clog2(IMG_W);
    localparam int HALF_W = IMG_W / 2;
    localparam logic [ACC_W-1:0] MAX_OUT =
        ACC_W'(cpn_pkg::NTAP * ((1 << PIX_W) - 1) * ((1 << (WGT_W - 1)) - 1));

    typedef struct packed {
        logic [ACC_W-1:0]              left;
        logic [HALF_W-1:0][ACC_W:0]    rowbuf;
        logic                          ov;
        logic [ACC_W-1:0]              od;
    } pool_t;

    pool_t            st_d, st_q;
    logic [ACC_W:0]   pair;
    logic [ACC_W+1:0] total;
    logic [COL_W-2:0] idx;

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        idx     = conv_c_i[COL_W-1:1];
        pair    = {1'b0, st_q.left} + {1'b0, conv_i};
        total   = {1'b0, st_q.rowbuf[idx]} + {1'b0, pair};
        if (conv_valid_i && !frame_start_i) begin
            if (!conv_c_i[0]) begin
                st_d.left = conv_i;
            end else if (!conv_rodd_i) begin
                st_d.rowbuf[idx] = pair;
            end else begin
                st_d.ov = 1'b1;
                st_d.od = ACC_W'(total >> 2);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o = st_q.ov;
    assign out_o       = st_q.od;

    p_out_odd_corner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(conv_valid_i && conv_rodd_i && conv_c_i[0]));

    p_out_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (out_o <= MAX_OUT));
endmodule

// File: rtl/conv_pool_node.sv
module conv_pool_node
    import cpn_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 16,
    parameter int PIX_W = 8,
    parameter int WGT_W = 8,
    parameter int ACC_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_start,
    input  logic                     pix_valid,
    input  logic [PIX_W-1:0]         pix_data,
    input  logic                     wgt_we,
    input  logic [$clog2(NTAP)-1:0]  wgt_sel,
    input  logic [WGT_W-1:0]         wgt_data,
    output logic                     out_valid,
    output logic [ACC_W-1:0]         out_data
);
    localparam int COL_W = $clog2(IMG_W);

    logic [NTAP-1:0][PIX_W-1:0] taps;
    logic                       cen_valid, cen_rodd;
    logic [COL_W-1:0]           cen_c;
    logic                       conv_valid, conv_rodd;
    logic [COL_W-1:0]           conv_c;
    logic [ACC_W-1:0]           conv_val;

    cpn_window #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W)) u_window (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start),
        .pix_valid_i(pix_valid), .pix_i(pix_data), .taps_o(taps),
        .cen_valid_o(cen_valid), .cen_rodd_o(cen_rodd), .cen_c_o(cen_c)
    );

    cpn_mac #(.IMG_W(IMG_W), .PIX_W(PIX_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start),
        .wgt_we_i(wgt_we), .wgt_sel_i(wgt_sel), .wgt_i(wgt_data),
        .taps_i(taps), .cen_valid_i(cen_valid), .cen_rodd_i(cen_rodd), .cen_c_i(cen_c),
        .conv_valid_o(conv_valid), .conv_rodd_o(conv_rodd), .conv_c_o(conv_c), .conv_o(conv_val)
    );

    cpn_pool #(.IMG_W(IMG_W), .PIX_W(PIX_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_pool (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start),
        .conv_valid_i(conv_valid), .conv_rodd_i(conv_rodd), .conv_c_i(conv_c), .conv_i(conv_val),
        .out_valid_o(out_valid), .out_o(out_data)
    );

    p_frame_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !out_valid);
endmodule

// File: tb/conv_pool_node_bench.sv
module conv_pool_node_bench;
    localparam int W = 16;
    localparam int H = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_data = '0;
    logic        wgt_we = 1'b0;
    logic [3:0]  wgt_sel = '0;
    logic [7:0]  wgt_data = '0;
    logic        out_valid;
    logic [19:0] out_data;

    always #5 clk = ~clk;

    conv_pool_node u_conv_pool_node (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .wgt_we(wgt_we), .wgt_sel(wgt_sel), .wgt_data(wgt_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    int    img [W*H];
    int    wm [9];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    int    due_q [$];
    int    val_q [$];
    int    ph = 0;
    int    pos = 0;
    int    seed = 7;
    bit    done = 1'b0;
    string req = "R1";

    function automatic int conv_ref(int r, int c);
        int acc = 0;
        for (int dy = -1; dy <= 1; dy++) begin
            for (int dx = -1; dx <= 1; dx++) begin
                if (r + dy >= 0 && r + dy < H && c + dx >= 0 && c + dx < W)
                    acc += wm[(dy + 1) * 3 + dx + 1] * img[(r + dy) * W + c + dx];
            end
        end
        return (acc < 0) ? 0 : acc;
    endfunction

    function automatic int pool_ref(int bi, int bj);
        int s = 0;
        for (int y = 0; y < 2; y++)
            for (int x = 0; x < 2; x++)
                s += conv_ref(2 * bi + y, 2 * bj + x);
        return s / 4;
    endfunction

    // Behavioural model: stream position counting and result scheduling.
    always @(posedge clk) begin
        int m;
        bit tick;
        cyc = cyc + 1;
        if (!rst_n) begin
            ph = 0;
            due_q.delete();
            val_q.delete();
            for (int k = 0; k < 9; k++) wm[k] = 0;
        end else begin
            if (frame_start) begin
                ph = 1;
                pos = 0;
                due_q.delete();
                val_q.delete();
            end else begin
                tick = (ph == 1 && pix_valid) || (ph == 2);
                if (tick) begin
                    if (pos >= W + 1) begin
                        m = pos - W - 1;
                        if ((m / W) % 2 == 1 && (m % W) % 2 == 1) begin
                            due_q.push_back(cyc + 2);
                            val_q.push_back(pool_ref((m / W) / 2, (m % W) / 2));
                        end
                    end
                    if (ph == 1 && pos == W * H - 1) ph = 2;
                    else if (ph == 2 && pos == W * H + W) ph = 0;
                    pos = pos + 1;
                end
            end
            if (wgt_we && wgt_sel < 9) wm[wgt_sel] = int'($signed(wgt_data));
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        bit exp_v;
        int exp_d;
        if (!rst_n) begin
            n_chk++;
            if (out_valid !== 1'b0) begin
                n_bad++;
                $display("FAIL R1 reset: out_valid=%0b expected 0", out_valid);
            end
        end else if (!done) begin
            exp_v = (due_q.size() > 0 && due_q[0] == cyc);
            exp_d = exp_v ? val_q[0] : 0;
            n_chk++;
            if (out_valid !== exp_v || (exp_v && out_data !== 20'(exp_d))) begin
                n_bad++;
                $display("FAIL %s cycle %0d: out_valid=%0b out_data=%0d, expected out_valid=%0b out_data=%0d",
                         req, cyc, out_valid, out_data, exp_v, exp_d);
            end
            if (exp_v) begin
                void'(due_q.pop_front());
                void'(val_q.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R7 watchdog: cycle %0d, expected end before 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic put_w(int k, int v);
        @(negedge clk);
        wgt_we = 1'b1;
        wgt_sel = 4'(k);
        wgt_data = 8'(v);
        @(negedge clk);
        wgt_we = 1'b0;
    endtask

    task automatic fill(int mode);
        for (int k = 0; k < W * H; k++) begin
            case (mode)
                0: img[k] = ((k / W) * 13 + (k % W) * 7) % 256;
                1: begin
                    seed = seed * 1103515245 + 12345;
                    img[k] = (seed >>> 16) & 255;
                end
                2: img[k] = 255;
                default: img[k] = (((k / W) + (k % W)) % 2 == 1) ? 255 : 0;
            endcase
        end
    endtask

    // Send a frame: gap_mod>0 inserts idle cycles, npix<256 abandons the frame.
    task automatic run_frame(int gap_mod, int npix, bit fs_pix);
        @(negedge clk);
        frame_start = 1'b1;
        pix_valid = fs_pix;
        pix_data = 8'hAB;
        @(negedge clk);
        frame_start = 1'b0;
        pix_valid = 1'b0;
        for (int k = 0; k < npix; k++) begin
            if (gap_mod > 0 && k % gap_mod == gap_mod - 1) begin
                pix_valid = 1'b0;
                @(negedge clk);
            end
            pix_valid = 1'b1;
            pix_data = img[k][7:0];
            @(negedge clk);
        end
        if (npix == W * H) begin
            for (int k = 0; k < W + 6; k++) begin
                pix_valid = 1'b1;
                pix_data = 8'(200 + k);
                @(negedge clk);
            end
        end
        pix_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: pixels with no frame open are ignored
        req = "R1";
        for (int k = 0; k < 40; k++) begin
            pix_valid = 1'b1;
            pix_data = 8'(k * 5);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        repeat (4) @(negedge clk);

        // R5: centre-only weight, pooling of plain pixels
        req = "R5";
        put_w(4, 1);
        fill(0);
        run_frame(0, W * H, 1'b0);

        // R3: asymmetric signed weights check tap order and zero padding
        req = "R3";
        for (int k = 0; k < 9; k++) put_w(k, (k % 2 == 0) ? (k + 1) : -(k + 1));
        fill(1);
        run_frame(0, W * H, 1'b0);

        // R7: stalls in the pixel stream
        req = "R7";
        fill(1);
        run_frame(3, W * H, 1'b0);

        // R2: out-of-range selectors leave the weights untouched
        req = "R2";
        put_w(12, 100);
        put_w(9, -50);
        put_w(15, 77);
        fill(0);
        run_frame(0, W * H, 1'b0);

        // R4: mostly negative kernel makes the activation clamp
        req = "R4";
        for (int k = 0; k < 9; k++) put_w(k, (k == 4) ? 6 : -1);
        fill(3);
        run_frame(0, W * H, 1'b0);
        fill(1);
        run_frame(2, W * H, 1'b0);

        // R4: extreme weights and pixels at the upper bound, then all clamped
        for (int k = 0; k < 9; k++) put_w(k, 127);
        fill(2);
        run_frame(0, W * H, 1'b0);
        for (int k = 0; k < 9; k++) put_w(k, -128);
        run_frame(0, W * H, 1'b0);

        // R9: abandon a frame part way, then send a clean one
        req = "R9";
        for (int k = 0; k < 9; k++) put_w(k, k - 3);
        fill(1);
        run_frame(0, 150, 1'b0);
        fill(0);
        run_frame(0, W * H, 1'b0);

        // R10: pixel alongside frame_start is not taken
        req = "R10";
        fill(1);
        run_frame(0, W * H, 1'b1);

        // R6 and R8: output timing and self-driven padding with pix_valid held high
        req = "R6";
        fill(3);
        run_frame(5, W * H, 1'b0);
        req = "R8";
        fill(1);
        run_frame(0, W * H, 1'b0);

        repeat (5) @(negedge clk);
        if (due_q.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R6 end: %0d results outstanding, expected 0", due_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule